// File: doc/BRIEF.md
# Black Level Correction Loop With Timed Gain Boost

This block is the digital half of an optical-black calibration loop for an image sensor front end. On every pixel clock that falls inside the black reference window it compares the converter output code with a programmed 7-bit black target. When the code sits above the target it emits a down correction. When the code sits below it emits an up correction. The correction moves an internal offset accumulator that drives an external offset DAC or charge pump. Outside the window the accumulator keeps its value and no correction is issued.

To speed up settling after the host reprograms the front end, the loop gain can be boosted. A serial access, seen as the falling edge of chip select, arms a counter of black-window pulses. While fewer than N pulses have ended, the accumulator moves by a large step instead of a small one. A configuration bit can also force high gain permanently. The window can come from the alternate calibration pulse when the direct input feeds the gain stage, and its active level can be inverted. The accumulator returns to mid-scale on a register clear, on power-down from either the pin or the register, and on reset.

Top module: `blk_loop_top`

## Requirements
- R1: After reset corrUp and corrDn are 0, highGain is 0, and offsetCode is mid-scale (128 for the default 8-bit accumulator).
- R2: In an active window cycle where pixCode is above the target, corrDn is 1 after the next clock edge and offsetCode drops by the step. Where pixCode is below the target, corrUp is 1 and offsetCode rises by the step.
- R3: In an active window cycle where pixCode equals the target, neither correction is asserted and offsetCode is unchanged. corrUp and corrDn are never both 1.
- R4: In a cycle with the window inactive, corrUp and corrDn are 0 after the next edge and offsetCode holds its value.
- R5: A target value of 0 is forbidden and is treated as the default target of 64.
- R6: While any of blkClear=1, regPowerDown=1 or stbyN=0 holds, offsetCode is forced to mid-scale after the next edge and no correction is issued.
- R7: With adinToGain=1 the window is taken from calPulse and obWin has no effect. With adinToGain=0 the window is taken from obWin.
- R8: With winInvert=1 the selected window input is active low. With winInvert=0 it is active high.
- R9: With boostCfg[3]=0 and N=boostCfg[2:0] from 1 to 7, highGain goes to 1 after the edge that samples a falling csN. It returns to 0 once N active-window deassertions have followed. A window pulse already active at the chip-select edge is not counted.
- R10: With boostCfg=0 highGain stays 0 even after a serial access. With boostCfg[3]=1 highGain is 1 with or without an access.
- R11: While highGain is 1, each correction moves offsetCode by 4 (HIGH_STEP). While highGain is 0, each correction moves it by 1 (LOW_STEP).
- R12: offsetCode saturates at 0 on down corrections and at its maximum (255) on up corrections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixCode | input | 10 | Converter output code |
| obWin | input | 1 | Optical black window pulse |
| calPulse | input | 1 | Alternate calibration window pulse |
| stbyN | input | 1 | Power-down pin, active low |
| csN | input | 1 | Serial chip select, active low; falling edge marks an access |
| tgtLevel | input | 7 | Black target code, 0 means 64 |
| boostCfg | input | 4 | Bit 3 forces high gain; bits 2:0 give the boost pulse count N |
| blkClear | input | 1 | Register clear of the accumulator |
| regPowerDown | input | 1 | Register power-down |
| adinToGain | input | 1 | Selects calPulse as the window |
| winInvert | input | 1 | Inverts the window polarity |
| corrUp | output | 1 | Up correction pulse |
| corrDn | output | 1 | Down correction pulse |
| highGain | output | 1 | Loop gain boost active |
| offsetCode | output | 8 | Offset accumulator value for the DAC |

## Verification
On every cycle the assertions check these rules: up and down are never asserted together, an inactive window freezes the accumulator and silences both corrections, any clear source lands the accumulator on mid-scale, and an up pulse never lowers the code. They also check that the boost counter moves only on a chip-select edge or a window deassertion, that a chip-select edge with a nonzero N raises high gain, and that a zero boost field keeps gain low. The bench scenarios show the direction and size of each step against a modelled accumulator, the substitution for a zero target, window source selection and inversion, and saturation at both ends. They also show the exact pulse at which boost ends, including the pulse that was already in progress at the access.

// File: rtl/blk_loop_pkg.sv
package blk_loop_pkg;
  typedef struct packed {
    logic winOn;
    logic clearAcc;
    logic highGain;
  } loopStrobe_t;
endpackage

// File: rtl/blk_loop_ctrl.sv
module blk_loop_ctrl
  import blk_loop_pkg::*;
#(
  parameter int BOOST_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               obWin,
  input  logic               calPulse,
  input  logic               stbyN,
  input  logic               csN,
  input  logic [BOOST_W:0]   boostCfg,
  input  logic               blkClear,
  input  logic               regPowerDown,
  input  logic               adinToGain,
  input  logic               winInvert,
  output loopStrobe_t        strb
);
  logic               winRaw, winAct, winPrev, winFall;
  logic               csPrev, csFall;
  logic               armed, skipNext;
  logic [BOOST_W-1:0] pulseCnt;
  logic [BOOST_W-1:0] boostN;
  logic               forceHigh, clearAny, gainHi;

  assign boostN    = boostCfg[BOOST_W-1:0];
  assign forceHigh = boostCfg[BOOST_W];
  assign winRaw    = adinToGain ? calPulse : obWin;
  assign winAct    = winRaw ^ winInvert;
  assign clearAny  = blkClear | regPowerDown | ~stbyN;
  assign winFall   = winPrev & ~winAct;
  assign csFall    = csPrev & ~csN;
  assign gainHi    = forceHigh | (armed & (pulseCnt < boostN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      winPrev <= winAct;
      csPrev  <= csN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      skipNext <= 1'b0;
      pulseCnt <= '0;
    end else if (csFall) begin
      armed    <= 1'b1;
      skipNext <= winAct;
      pulseCnt <= '0;
    end else if (winFall) begin
      if (skipNext) begin
        skipNext <= 1'b0;
      end else if (armed && (pulseCnt < boostN)) begin
        pulseCnt <= pulseCnt + 1'b1;
      end
    end
  end

  assign strb.winOn    = winAct & ~clearAny;
  assign strb.clearAcc = clearAny;
  assign strb.highGain = gainHi;

  // R9: the counter only moves on an access or a window deassertion
  p_cnt_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!csFall && !winFall) |=> $stable(pulseCnt));
  // R9: an access with a nonzero count raises the gain on the next cycle
  p_boost_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csFall && !forceHigh && (boostN != '0) && $stable(boostCfg)) |=> gainHi);
  // R10: an all-zero boost field never gives high gain
  p_zero_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (boostCfg == '0) |-> !gainHi);
endmodule

// File: rtl/blk_loop_dp.sv
module blk_loop_dp
  import blk_loop_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int TGT_W       = 7,
  parameter int ACC_W       = 8,
  parameter int TGT_DEFAULT = 64,
  parameter int LOW_STEP    = 1,
  parameter int HIGH_STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] pixCode,
  input  logic [TGT_W-1:0]  tgtLevel,
  input  loopStrobe_t       strb,
  output logic              corrUp,
  output logic              corrDn,
  output logic [ACC_W-1:0]  offsetCode
);
  localparam logic [ACC_W-1:0] MID_CODE = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] MAX_CODE = {ACC_W{1'b1}};
  localparam logic [ACC_W-1:0] STEP_LO  = ACC_W'(LOW_STEP);
  localparam logic [ACC_W-1:0] STEP_HI  = ACC_W'(HIGH_STEP);
  localparam logic [TGT_W-1:0] TGT_DEF  = TGT_W'(TGT_DEFAULT);

  logic [TGT_W-1:0]  tgtEff;
  logic [CODE_W-1:0] tgtWide;
  logic              isAbove, isBelow;
  logic [ACC_W-1:0]  stepSize;

  assign tgtEff   = (tgtLevel == '0) ? TGT_DEF : tgtLevel;
  assign tgtWide  = {{(CODE_W-TGT_W){1'b0}}, tgtEff};
  assign isAbove  = pixCode > tgtWide;
  assign isBelow  = pixCode < tgtWide;
  assign stepSize = strb.highGain ? STEP_HI : STEP_LO;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetCode <= MID_CODE;
      corrUp     <= 1'b0;
      corrDn     <= 1'b0;
    end else if (strb.clearAcc) begin
      offsetCode <= MID_CODE;
      corrUp     <= 1'b0;
      corrDn     <= 1'b0;
    end else if (strb.winOn && isAbove) begin
      corrUp     <= 1'b0;
      corrDn     <= 1'b1;
      offsetCode <= (offsetCode < stepSize) ? '0 : offsetCode - stepSize;
    end else if (strb.winOn && isBelow) begin
      corrUp     <= 1'b1;
      corrDn     <= 1'b0;
      offsetCode <= (offsetCode > (MAX_CODE - stepSize)) ? MAX_CODE
                                                         : offsetCode + stepSize;
    end else begin
      corrUp <= 1'b0;
      corrDn <= 1'b0;
    end
  end

  // R3: up and down are mutually exclusive
  p_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(corrUp && corrDn));
  // R4: an inactive window freezes the accumulator
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.winOn && !strb.clearAcc) |=> ($stable(offsetCode) && !corrUp && !corrDn));
  // R6: any clear source lands on mid-scale
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAcc |=> (offsetCode == MID_CODE));
  // R2: an up pulse never lowers the code
  p_up_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(corrUp) |-> (offsetCode > $past(offsetCode)) || (offsetCode == MAX_CODE));
endmodule

// File: rtl/blk_loop_top.sv
module blk_loop_top
  import blk_loop_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int TGT_W       = 7,
  parameter int ACC_W       = 8,
  parameter int BOOST_W     = 3,
  parameter int TGT_DEFAULT = 64,
  parameter int LOW_STEP    = 1,
  parameter int HIGH_STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] pixCode,
  input  logic              obWin,
  input  logic              calPulse,
  input  logic              stbyN,
  input  logic              csN,
  input  logic [TGT_W-1:0]  tgtLevel,
  input  logic [BOOST_W:0]  boostCfg,
  input  logic              blkClear,
  input  logic              regPowerDown,
  input  logic              adinToGain,
  input  logic              winInvert,
  output logic              corrUp,
  output logic              corrDn,
  output logic              highGain,
  output logic [ACC_W-1:0]  offsetCode
);
  loopStrobe_t strb;

  blk_loop_ctrl #(.BOOST_W(BOOST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .obWin(obWin), .calPulse(calPulse),
    .stbyN(stbyN), .csN(csN), .boostCfg(boostCfg), .blkClear(blkClear),
    .regPowerDown(regPowerDown), .adinToGain(adinToGain),
    .winInvert(winInvert), .strb(strb)
  );

  blk_loop_dp #(
    .CODE_W(CODE_W), .TGT_W(TGT_W), .ACC_W(ACC_W),
    .TGT_DEFAULT(TGT_DEFAULT), .LOW_STEP(LOW_STEP), .HIGH_STEP(HIGH_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pixCode(pixCode), .tgtLevel(tgtLevel),
    .strb(strb), .corrUp(corrUp), .corrDn(corrDn), .offsetCode(offsetCode)
  );

  assign highGain = strb.highGain;
endmodule

// File: tb/blk_loop_top_test.sv
module blk_loop_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] pixCode = '0;
  logic       obWin = 1'b0, calPulse = 1'b0, stbyN = 1'b1, csN = 1'b1;
  logic [6:0] tgtLevel = 7'd64;
  logic [3:0] boostCfg = '0;
  logic       blkClear = 1'b0, regPowerDown = 1'b0, adinToGain = 1'b0, winInvert = 1'b0;
  logic       corrUp, corrDn, highGain;
  logic [7:0] offsetCode;

  int nChecks = 0;
  int nFail = 0;
  int expAcc = 128;
  bit done = 0;

  always #10 clk = ~clk;

  blk_loop_top uut (
    .clk(clk), .rstN(rstN), .pixCode(pixCode), .obWin(obWin), .calPulse(calPulse),
    .stbyN(stbyN), .csN(csN), .tgtLevel(tgtLevel), .boostCfg(boostCfg),
    .blkClear(blkClear), .regPowerDown(regPowerDown), .adinToGain(adinToGain),
    .winInvert(winInvert), .corrUp(corrUp), .corrDn(corrDn),
    .highGain(highGain), .offsetCode(offsetCode)
  );

  // {code[19:10], target[9:3], window[2], expUp[1], expDn[0]}
  localparam logic [19:0] VEC [13] = '{
    {10'd100,  7'd64,  1'b1, 2'b01},
    {10'd10,   7'd64,  1'b1, 2'b10},
    {10'd64,   7'd64,  1'b1, 2'b00},
    {10'd500,  7'd127, 1'b1, 2'b01},
    {10'd126,  7'd127, 1'b1, 2'b10},
    {10'd16,   7'd16,  1'b1, 2'b00},
    {10'd300,  7'd64,  1'b0, 2'b00},
    {10'd0,    7'd1,   1'b1, 2'b10},
    {10'd1,    7'd1,   1'b1, 2'b00},
    {10'd64,   7'd0,   1'b1, 2'b00},
    {10'd65,   7'd0,   1'b1, 2'b01},
    {10'd63,   7'd0,   1'b1, 2'b10},
    {10'd1023, 7'd127, 1'b1, 2'b01}
  };

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelStep(input int up, input int dn, input int step);
    if (up != 0) expAcc = (expAcc + step > 255) ? 255 : expAcc + step;
    if (dn != 0) expAcc = (expAcc < step) ? 0 : expAcc - step;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    #35;
    rstN = 1'b1;
    cyc();
    chk("R1 up", corrUp, 0);
    chk("R1 dn", corrDn, 0);
    chk("R1 highGain", highGain, 0);
    chk("R1 offset", offsetCode, 128);

    // vector walk, low gain: R2 R3 R4 R5
    foreach (VEC[i]) begin
      pixCode  = VEC[i][19:10];
      tgtLevel = VEC[i][9:3];
      obWin    = VEC[i][2];
      cyc();
      modelStep(VEC[i][1], VEC[i][0], 1);
      chk($sformatf("R2/R3/R4/R5 vec%0d up", i), corrUp, VEC[i][1]);
      chk($sformatf("R2/R3/R4/R5 vec%0d dn", i), corrDn, VEC[i][0]);
      chk($sformatf("R2/R3/R4/R5 vec%0d offset", i), offsetCode, expAcc);
    end
    obWin = 1'b0;
    cyc();
    chk("R4 idle up", corrUp, 0);

    // R6 clear sources, window active with code above target
    tgtLevel = 7'd64; pixCode = 10'd200; obWin = 1'b1;
    blkClear = 1'b1; cyc(); blkClear = 1'b0;
    expAcc = 128;
    chk("R6 blkClear offset", offsetCode, 128);
    chk("R6 blkClear dn", corrDn, 0);
    cyc(); modelStep(0, 1, 1);
    regPowerDown = 1'b1; cyc(); regPowerDown = 1'b0;
    expAcc = 128;
    chk("R6 regPowerDown offset", offsetCode, 128);
    cyc(); modelStep(0, 1, 1);
    stbyN = 1'b0; cyc();
    expAcc = 128;
    chk("R6 stbyN offset", offsetCode, 128);
    chk("R6 stbyN dn", corrDn, 0);
    stbyN = 1'b1; obWin = 1'b0; cyc();

    // R7 window source
    adinToGain = 1'b1; obWin = 1'b1; calPulse = 1'b0; cyc();
    chk("R7 obWin ignored dn", corrDn, 0);
    chk("R7 obWin ignored offset", offsetCode, expAcc);
    calPulse = 1'b1; cyc(); modelStep(0, 1, 1);
    chk("R7 calPulse dn", corrDn, 1);
    chk("R7 calPulse offset", offsetCode, expAcc);
    adinToGain = 1'b0; calPulse = 1'b0; obWin = 1'b0; cyc();

    // R8 polarity inversion
    winInvert = 1'b1; obWin = 1'b0; cyc(); modelStep(0, 1, 1);
    chk("R8 inverted low active dn", corrDn, 1);
    chk("R8 inverted offset", offsetCode, expAcc);
    obWin = 1'b1; cyc();
    chk("R8 inverted high idle dn", corrDn, 0);
    chk("R8 inverted high offset", offsetCode, expAcc);
    winInvert = 1'b0; obWin = 1'b0; cyc();

    // R9 boost for N=3, code equals target so accumulator stays
    pixCode = 10'd64; boostCfg = 4'd3;
    csN = 1'b0; cyc();
    chk("R9 access raises gain", highGain, 1);
    csN = 1'b1; cyc();
    for (int p = 0; p < 3; p++) begin
      obWin = 1'b1; cyc();
      obWin = 1'b0; cyc();
      chk($sformatf("R9 after pulse %0d", p + 1), highGain, (p < 2) ? 1 : 0);
    end
    // R9 pulse in progress at access is not counted
    obWin = 1'b1; cyc();
    csN = 1'b0; cyc();
    csN = 1'b1; obWin = 1'b0; cyc();
    chk("R9 in-progress pulse skipped", highGain, 1);
    for (int p = 0; p < 3; p++) begin
      obWin = 1'b1; cyc();
      obWin = 1'b0; cyc();
      chk($sformatf("R9 skip case pulse %0d", p + 1), highGain, (p < 2) ? 1 : 0);
    end

    // R10 zero field and forced high
    boostCfg = 4'd0; csN = 1'b0; cyc(); csN = 1'b1; cyc();
    chk("R10 zero field low", highGain, 0);
    boostCfg = 4'd8; cyc();
    chk("R10 forced high", highGain, 1);

    // R11 high-gain step size
    pixCode = 10'd200; obWin = 1'b1; cyc(); modelStep(0, 1, 4);
    chk("R11 high step offset", offsetCode, expAcc);
    pixCode = 10'd5; cyc(); modelStep(1, 0, 4);
    chk("R11 high step up offset", offsetCode, expAcc);
    boostCfg = 4'd0; cyc(); modelStep(1, 0, 1);
    chk("R11 low step offset", offsetCode, expAcc);

    // R12 saturation at both ends with forced high gain
    boostCfg = 4'd8; pixCode = 10'd900;
    for (int k = 0; k < 40; k++) begin cyc(); modelStep(0, 1, 4); end
    chk("R12 floor", offsetCode, 0);
    chk("R12 floor model", expAcc, 0);
    pixCode = 10'd0;
    for (int k = 0; k < 70; k++) begin cyc(); modelStep(1, 0, 4); end
    chk("R12 ceiling", offsetCode, 255);
    chk("R12 ceiling up", corrUp, 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule